// File: doc/BRIEF.md
# Auto-Baud UART Receiver

This block is the receive half of a slave-only asynchronous serial link whose rate is not fixed in advance. The master opens every frame with a synchronization field carrying the byte 0x55. The receiver times that field against the system clock and derives the bit period from it. It then locks and samples the byte fields that follow at the middle of each bit. The frame controller re-arms the receiver at the start of each frame, so that the next field on the line is measured again as a sync field.

Each field on the line is one start bit at logic 0, eight data bits with the least significant bit first, and one stop bit at logic 1. The idle level is logic 1. The measured period is also published in clock cycles, so that a companion transmitter can answer at the same rate. Supported rates run from MIN_BAUD to MAX_BAUD, which default to 2400 and 115200 bps. A sync field timed outside that window leaves the receiver unlocked.

Top module: `abr_rx`

## Requirements
- R1: While `rst` is high and after it is released, `locked_o`, `byte_valid_o` and `frame_err_o` are 0, and `bit_period_o` is 0.
- R2: When unlocked, a 0x55 field sent with bit period T cycles, where T lies from CLK_HZ/MAX_BAUD to CLK_HZ/MIN_BAUD, sets `locked_o` to 1 and `bit_period_o` to T. T is the interval from the start-bit falling edge to the falling edge of data bit 7, shifted right by 3.
- R3: Once locked, a field with a stop bit at 1 produces exactly one `byte_valid_o` pulse. `byte_o` then holds the eight data bits, where the first data bit on the line is bit 0.
- R4: A sync field whose measured period lies below CLK_HZ/MAX_BAUD or above CLK_HZ/MIN_BAUD leaves `locked_o` at 0. A measurement whose span passes 8*(CLK_HZ/MIN_BAUD)+7 cycles is abandoned. While unlocked, no `byte_valid_o` pulse is produced.
- R5: A locked field whose stop bit is sampled at 0 gives a one-cycle `frame_err_o` pulse and no `byte_valid_o` pulse.
- R6: A cycle with `rearm_i` high clears `locked_o` in the next cycle. The next falling edge then starts a new sync measurement, which may set a different period.
- R7: The start bit is sampled half a period after its falling edge, and each later bit one period after the one before it. A field sent 2.5 % faster or slower than the measured rate is therefore still received correctly.
- R8: A low pulse shorter than half a bit period, when locked, is a false start. It gives neither `byte_valid_o` nor `frame_err_o`, and the next proper field is received.
- R9: `byte_valid_o` and `frame_err_o` are single-cycle pulses and are never high together.
- R10: `locked_o` and `bit_period_o` hold their values until `rearm_i` is raised, whatever the line does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line, idle high |
| rearm_i | input | 1 | Clear lock and measure the next field as sync |
| byte_o | output | 8 | Last byte received without error |
| byte_valid_o | output | 1 | One-cycle strobe for a new byte |
| frame_err_o | output | 1 | One-cycle strobe for a stop bit sampled low |
| locked_o | output | 1 | A valid bit period has been measured |
| bit_period_o | output | PER_W | Measured bit period in clock cycles |

## Verification
Sync fields are sent at both ends of the supported period range, at mid-range values, and at random periods. Exact period readback at each of these tells a correct divide-by-eight from an off-by-one in the span count. Bytes are drawn at random and from directed values 0x00, 0xFF, 0x01, 0x80 and 0xA5; these separate a correct bit order from a reversed or shifted one. Fields sent 2.5 % off the measured rate, a short low glitch, a low stop bit and periods just outside the range tell midpoint sampling, false-start rejection, framing detection and range checking apart from their broken variants.

// File: rtl/abr_pkg.sv
package abr_pkg;
    localparam int DATA_BITS  = 8;
    localparam int SPAN_SHIFT = $clog2(DATA_BITS);
    localparam int SYNC_FALLS = 4;

    typedef enum logic [1:0] {M_HUNT, M_SPAN, M_LOCK} meas_st_e;
    typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} samp_st_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 good;
        logic                 bad;
    } field_res_t;

    function automatic logic in_window(input int unsigned val, input int unsigned lo,
                                       input int unsigned hi);
        return (val >= lo) && (val <= hi);
    endfunction
endpackage

// File: rtl/abr_line_sync.sv
module abr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_i,
    output logic rx_o,
    output logic fall_o
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], rx_i};
    end

    assign rx_o   = sh[STAGES-1];
    assign fall_o = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/abr_meas.sv
module abr_meas
    import abr_pkg::*;
#(
    parameter int MIN_PERIOD = 10,
    parameter int MAX_PERIOD = 480,
    localparam int PER_W    = $clog2(MAX_PERIOD + 1),
    localparam int SPAN_MAX = MAX_PERIOD * DATA_BITS + DATA_BITS - 1,
    localparam int CNT_W    = $clog2(SPAN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rearm_i,
    input  logic             fall_i,
    output logic             lock_o,
    output logic [PER_W-1:0] period_o
);
    meas_st_e         st;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       falls;
    logic [CNT_W-1:0] per_c;
    logic             ok_c;

    always_comb begin
        per_c = cnt >> SPAN_SHIFT;
        ok_c  = in_window(32'(per_c), MIN_PERIOD, MAX_PERIOD);
    end

    always_ff @(posedge clk) begin
        if (rst || rearm_i) begin
            st    <= M_HUNT;
            cnt   <= '0;
            falls <= '0;
            if (rst) period_o <= '0;
        end else begin
            case (st)
                M_HUNT: if (fall_i) begin
                    st    <= M_SPAN;
                    cnt   <= CNT_W'(1);
                    falls <= '0;
                end
                M_SPAN: begin
                    if (fall_i) begin
                        if (falls == 3'(SYNC_FALLS - 1)) begin
                            if (ok_c) begin
                                st       <= M_LOCK;
                                period_o <= PER_W'(per_c);
                            end else begin
                                st <= M_HUNT;
                            end
                        end else begin
                            falls <= falls + 3'd1;
                            cnt   <= cnt + CNT_W'(1);
                        end
                    end else if (cnt == CNT_W'(SPAN_MAX)) begin
                        st <= M_HUNT;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign lock_o = (st == M_LOCK);
endmodule

// File: rtl/abr_sampler.sv
module abr_sampler
    import abr_pkg::*;
#(
    parameter int PER_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rearm_i,
    input  logic             rx_i,
    input  logic             fall_i,
    input  logic             lock_i,
    input  logic [PER_W-1:0] period_i,
    output field_res_t       res_o
);
    samp_st_e             st;
    logic [PER_W-1:0]     cnt;
    logic [2:0]           idx;
    logic [DATA_BITS-1:0] sh;
    logic [PER_W-1:0]     half;

    assign half = period_i >> 1;

    always_ff @(posedge clk) begin
        if (rst || rearm_i) begin
            st         <= S_IDLE;
            cnt        <= '0;
            idx        <= '0;
            sh         <= '0;
            res_o.good <= 1'b0;
            res_o.bad  <= 1'b0;
            if (rst) res_o.data <= '0;
        end else begin
            res_o.good <= 1'b0;
            res_o.bad  <= 1'b0;
            case (st)
                S_IDLE: if (lock_i && fall_i) begin
                    st  <= S_START;
                    cnt <= PER_W'(1);
                end
                S_START: begin
                    if (cnt == half) begin
                        cnt <= PER_W'(1);
                        idx <= '0;
                        st  <= rx_i ? S_IDLE : S_DATA;
                    end else begin
                        cnt <= cnt + PER_W'(1);
                    end
                end
                S_DATA: begin
                    if (cnt == period_i) begin
                        cnt <= PER_W'(1);
                        sh  <= {rx_i, sh[DATA_BITS-1:1]};
                        idx <= idx + 3'd1;
                        if (idx == 3'(DATA_BITS - 1)) st <= S_STOP;
                    end else begin
                        cnt <= cnt + PER_W'(1);
                    end
                end
                S_STOP: begin
                    if (cnt == period_i) begin
                        st <= S_IDLE;
                        if (rx_i) begin
                            res_o.good <= 1'b1;
                            res_o.data <= sh;
                        end else begin
                            res_o.bad <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + PER_W'(1);
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/abr_rx.sv
module abr_rx
    import abr_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int MIN_BAUD    = 2400,
    parameter int MAX_BAUD    = 115200,
    parameter int SYNC_STAGES = 2,
    localparam int MIN_PERIOD = CLK_HZ / MAX_BAUD,
    localparam int MAX_PERIOD = CLK_HZ / MIN_BAUD,
    localparam int PER_W      = $clog2(MAX_PERIOD + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_i,
    input  logic                 rearm_i,
    output logic [DATA_BITS-1:0] byte_o,
    output logic                 byte_valid_o,
    output logic                 frame_err_o,
    output logic                 locked_o,
    output logic [PER_W-1:0]     bit_period_o
);
    logic       rx_s;
    logic       fall;
    field_res_t res;

    abr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .rx_i(rx_i), .rx_o(rx_s), .fall_o(fall)
    );

    abr_meas #(.MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD)) u_meas (
        .clk(clk), .rst(rst), .rearm_i(rearm_i), .fall_i(fall),
        .lock_o(locked_o), .period_o(bit_period_o)
    );

    abr_sampler #(.PER_W(PER_W)) u_samp (
        .clk(clk), .rst(rst), .rearm_i(rearm_i), .rx_i(rx_s), .fall_i(fall),
        .lock_i(locked_o), .period_i(bit_period_o), .res_o(res)
    );

    assign byte_o       = res.data;
    assign byte_valid_o = res.good;
    assign frame_err_o  = res.bad;
endmodule

// File: rtl/abr_rx_chk.sv
module abr_rx_chk #(
    parameter int MIN_PERIOD = 10,
    parameter int MAX_PERIOD = 480,
    parameter int PER_W      = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             rearm_i,
    input logic             byte_valid_o,
    input logic             frame_err_o,
    input logic             locked_o,
    input logic [PER_W-1:0] bit_period_o
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!locked_o && !byte_valid_o && !frame_err_o));

    assert_period_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        locked_o |-> (32'(bit_period_o) >= MIN_PERIOD && 32'(bit_period_o) <= MAX_PERIOD));

    assert_valid_needs_lock_R3: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |-> locked_o);

    assert_rearm_unlocks_R6: assert property (@(posedge clk) disable iff (rst)
        rearm_i |=> !locked_o);

    assert_lock_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (locked_o && !rearm_i) |=> (locked_o && $stable(bit_period_o)));

    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |=> !byte_valid_o);

    assert_ferr_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |=> !frame_err_o);

    assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(byte_valid_o && frame_err_o));
endmodule

bind abr_rx abr_rx_chk #(
    .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD), .PER_W(PER_W)
) u_chk (
    .clk(clk), .rst(rst), .rearm_i(rearm_i), .byte_valid_o(byte_valid_o),
    .frame_err_o(frame_err_o), .locked_o(locked_o), .bit_period_o(bit_period_o)
);

// File: tb/abr_rx_bench.sv
module abr_rx_bench;
    localparam int CLK_HZ   = 1_152_000;
    localparam int MIN_BAUD = 2400;
    localparam int MAX_BAUD = 115200;
    localparam int P_MIN    = CLK_HZ / MAX_BAUD;
    localparam int P_MAX    = CLK_HZ / MIN_BAUD;
    localparam int PW       = $clog2(P_MAX + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx = 1'b1;
    logic          rearm = 1'b0;
    logic [7:0]    rbyte;
    logic          rvalid, rferr, rlock;
    logic [PW-1:0] rper;

    int   vcnt = 0, fcnt = 0, dup = 0, checks = 0, fails = 0;
    logic [7:0] last = 8'h00;
    logic prev_v = 1'b0, prev_f = 1'b0;

    always #2 clk = ~clk;

    abr_rx #(.CLK_HZ(CLK_HZ), .MIN_BAUD(MIN_BAUD), .MAX_BAUD(MAX_BAUD)) u_abr_rx (
        .clk(clk), .rst(rst), .rx_i(rx), .rearm_i(rearm), .byte_o(rbyte),
        .byte_valid_o(rvalid), .frame_err_o(rferr), .locked_o(rlock), .bit_period_o(rper)
    );

    always @(negedge clk) begin
        if (rvalid) begin vcnt++; last = rbyte; end
        if (rferr) fcnt++;
        if ((rvalid && prev_v) || (rferr && prev_f) || (rvalid && rferr)) dup++;
        prev_v = rvalid;
        prev_f = rferr;
    end

    function automatic bit exp_lock(input int t);
        return (t >= P_MIN) && (t <= P_MAX);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_field(input logic [7:0] b, input int t, input bit stop_hi);
        hold(1'b0, t);
        for (int i = 0; i < 8; i++) hold(b[i], t);
        hold(stop_hi, t);
        hold(1'b1, t);
    endtask

    task automatic do_rearm();
        @(negedge clk);
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
        chk(rlock == 1'b0, "R6", "lock after rearm", int'(rlock), 0);
    endtask

    task automatic sync_and_check(input int t, input string req);
        send_field(8'h55, t, 1'b1);
        chk(rlock == exp_lock(t), req, $sformatf("lock for period %0d", t),
            int'(rlock), int'(exp_lock(t)));
        if (exp_lock(t))
            chk(int'(rper) == t, req, "measured period", int'(rper), t);
    endtask

    task automatic byte_check(input logic [7:0] b, input int t, input string req);
        int v0, f0;
        v0 = vcnt;
        f0 = fcnt;
        send_field(b, t, 1'b1);
        chk(vcnt == v0 + 1 && fcnt == f0, req, "one valid pulse", vcnt - v0, 1);
        chk(last == b, req, "byte value", int'(last), int'(b));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int v0, f0;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        chk(!rlock && !rvalid && !rferr && rper == '0, "R1", "reset state",
            int'({rlock, rvalid, rferr}), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(!rlock && vcnt == 0 && fcnt == 0, "R1", "after reset release",
            int'(rlock), 0);

        // R2 / R3 main path
        sync_and_check(40, "R2");
        byte_check(8'hA5, 40, "R3");
        byte_check(8'h00, 40, "R3");
        byte_check(8'hFF, 40, "R3");
        byte_check(8'h01, 40, "R3");
        byte_check(8'h80, 40, "R3");

        // R7 rate tolerance
        byte_check(8'h3C, 41, "R7");
        byte_check(8'hC3, 39, "R7");

        // R5 framing error
        v0 = vcnt; f0 = fcnt;
        send_field(8'h5A, 40, 1'b0);
        chk(fcnt == f0 + 1, "R5", "frame error pulses", fcnt - f0, 1);
        chk(vcnt == v0, "R5", "no valid on bad stop", vcnt - v0, 0);

        // R8 false start
        v0 = vcnt; f0 = fcnt;
        hold(1'b0, 8);
        hold(1'b1, 600);
        chk(vcnt == v0 && fcnt == f0, "R8", "glitch ignored", vcnt - v0 + fcnt - f0, 0);
        byte_check(8'h96, 40, "R8");
        chk(rlock && int'(rper) == 40, "R10", "lock held through traffic", int'(rper), 40);

        // R6 rearm and boundaries
        do_rearm();
        sync_and_check(P_MIN, "R6");
        byte_check(8'h6B, P_MIN, "R6");
        do_rearm();
        sync_and_check(P_MAX, "R2");
        byte_check(8'hD2, P_MAX, "R3");

        // R4 out of range
        do_rearm();
        sync_and_check(P_MIN - 2, "R4");
        v0 = vcnt;
        send_field(8'h00, P_MIN - 2, 1'b1);
        chk(vcnt == v0 && !rlock, "R4", "no byte while unlocked", vcnt - v0, 0);
        do_rearm();
        sync_and_check(P_MAX + 20, "R4");
        do_rearm();

        // random frames
        for (int f = 0; f < 12; f++) begin
            int t;
            t = P_MIN + int'($urandom_range(50, 0));
            do_rearm();
            sync_and_check(t, "R2");
            for (int k = 0; k < 3; k++) byte_check(8'($urandom), t, "R3");
            chk(rlock && int'(rper) == t, "R10", "lock held after frame", int'(rper), t);
        end

        chk(dup == 0, "R9", "single-cycle exclusive pulses", dup, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule